// File: doc/BRIEF.md
# Counter Stream Test Source

This block sits in front of the frame capture stage of a receive chain and chooses what that stage sees. It can pass through the channelizer output, pass through the raw bypass output, or generate a synthetic stream of its own. Every clock it presents one beat of four complex samples. Each sample has a 16-bit real half and a 16-bit imaginary half.

In counter mode every sample describes itself. The real half holds the sample's position inside a 512-sample frame, and the imaginary half holds the number of the frame. A receiver downstream of the capture and DMA path can therefore find dropped samples, reordered beats and misplaced frame boundaries just by reading the data.

The block always tracks frame position, whichever source is selected. It marks the last beat of every 128-beat frame for the capture stage. A change of source takes effect only at the start of a frame, so no frame ever mixes two sources.

The source choice is a small state machine with three states:
- `SRC_CHAN` forwards the channelizer data.
- `SRC_BYP` forwards the bypass data.
- `SRC_CNT` emits the counter pattern.

The state machine has two transitions:
- While no beat of the current frame has been emitted (the beat position is 0), the effective state is loaded from `mode_sel` every cycle.
- At any other beat position, the state holds.

After reset the state is `SRC_CNT`.

Top module: `cnt_stream_src`

## Requirements
- R1: While reset is low, `smp_valid` and `frame_end` are 0 and `smp_data` is all zeros. The first counter beat after reset carries samples 0 to 3 of frame 0.
- R2: Lane k sits at `smp_data[32k+31:32k]`, with the real half in the low 16 bits of the lane and the imaginary half in the high 16 bits. In counter mode, the real half of lane k on beat b of a frame equals 4*b+k, and lane 0 holds the earliest sample.
- R3: In counter mode, the imaginary half of all four lanes equals the current frame index, zero-extended to 16 bits.
- R4: After the beat carrying sample 511, the next counter beat starts again at sample 0, and the frame index is one higher.
- R5: `frame_end` is 1 exactly on output beats that are the 128th beat of a frame, which in counter mode is the beat whose lane 3 carries sample 511. `frame_end` is never 1 without `smp_valid`.
- R6: A cycle with `enable` low produces no valid beat one cycle later, and it leaves the beat position and frame index unchanged.
- R7: The frame index is FRAME_IDX_W bits wide and wraps from all ones back to 0.
- R8: `mode_sel` selects the source: 2'b00 selects channelizer, 2'b01 selects bypass, and 2'b10 or 2'b11 selects counter. A passthrough beat is emitted one cycle after the selected source's valid and `enable` are both high, carrying the source data unchanged.
- R9: A change of `mode_sel` in the middle of a frame is ignored until the beat with `frame_end` has been emitted. The new source is taken at the next frame start.
- R10: Beat position and frame index advance on every emitted beat in every mode. A counter frame that follows passthrough frames carries a frame index that counts those passthrough frames too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows beats to be emitted |
| mode_sel | input | 2 | Source select (00 channelizer, 01 bypass, 1x counter) |
| chan_data | input | 128 | Channelizer beat, four complex lanes |
| chan_valid | input | 1 | Channelizer beat present |
| byp_data | input | 128 | Bypass beat, four complex lanes |
| byp_valid | input | 1 | Bypass beat present |
| smp_data | output | 128 | Beat to the capture stage |
| smp_valid | output | 1 | Beat on `smp_data` is valid |
| frame_end | output | 1 | Last beat of a 512-sample frame |

## Verification
The counter pattern is first run with `enable` held high over whole frames, which exercises the lane ordering and the wrap at sample 511. It is then run with `enable` dropping on every third cycle, which separates a design that holds its counters from one that skips positions. Passthrough runs use source-valid gaps of different densities, and each beat carries a distinct payload, so a stale or duplicated beat cannot match. A switch of `mode_sel` in the middle of a frame, and a return to counter mode after passthrough frames, show whether the source changes only at frame starts and whether the frame count keeps running. A second instance with a 3-bit frame index runs past eight frames to show the wrap to 0.

// File: rtl/css_pkg.sv
package css_pkg;

    typedef enum logic [1:0] {
        SRC_CHAN = 2'b00,
        SRC_BYP  = 2'b01,
        SRC_CNT  = 2'b10
    } src_e;

    function automatic src_e sel_to_src(input logic [1:0] sel);
        src_e s;
        unique case (sel)
            2'b00:   s = SRC_CHAN;
            2'b01:   s = SRC_BYP;
            default: s = SRC_CNT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/css_frame_track.sv
module css_frame_track #(
    parameter int BEATS       = 128,
    parameter int FRAME_IDX_W = 16,
    localparam int BEAT_W     = $clog2(BEATS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    output logic [BEAT_W-1:0]      beat,
    output logic [FRAME_IDX_W-1:0] frame,
    output logic                   first_beat,
    output logic                   last_beat
);

    localparam logic [BEAT_W-1:0] LAST_POS = BEAT_W'(BEATS - 1);

    logic [BEAT_W-1:0]      beat_q;
    logic [FRAME_IDX_W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            frame_q <= '0;
        end else if (adv) begin
            if (beat_q == LAST_POS) begin
                beat_q  <= '0;
                frame_q <= frame_q + 1'b1;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        beat       = beat_q;
        frame      = frame_q;
        first_beat = (beat_q == '0);
        last_beat  = (beat_q == LAST_POS);
    end

    // R4
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last_beat) |=> (frame == FRAME_IDX_W'($past(frame) + 1'b1)));

    // R4
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last_beat) |=> first_beat);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(beat) && $stable(frame)));

endmodule

// File: rtl/css_pattern_gen.sv
module css_pattern_gen #(
    parameter int LANES       = 4,
    parameter int SAMPLE_W    = 16,
    parameter int FRAME_IDX_W = 16,
    parameter int BEAT_W      = 7,
    localparam int LANE_W     = $clog2(LANES),
    localparam int DATA_W     = LANES * 2 * SAMPLE_W
) (
    input  logic [BEAT_W-1:0]      beat,
    input  logic [FRAME_IDX_W-1:0] frame,
    output logic [DATA_W-1:0]      word
);

    logic [SAMPLE_W-1:0] imag_val;
    assign imag_val = SAMPLE_W'(frame);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE_ID = LANE_W'(k);
        logic [BEAT_W+LANE_W-1:0] pos;
        assign pos = {beat, LANE_ID};
        assign word[k*2*SAMPLE_W +: SAMPLE_W]            = SAMPLE_W'(pos);
        assign word[k*2*SAMPLE_W + SAMPLE_W +: SAMPLE_W] = imag_val;
    end

endmodule

// File: rtl/css_src_sel.sv
module css_src_sel
    import css_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode_sel,
    input  logic       first_beat,
    input  logic       chan_valid,
    input  logic       byp_valid,
    output src_e       src,
    output logic       fire
);

    src_e state_q;
    src_e state_d;

    always_comb begin
        if (first_beat) begin
            state_d = sel_to_src(mode_sel);
        end else begin
            state_d = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_CNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        src = state_d;
        unique case (state_d)
            SRC_CHAN: fire = enable && chan_valid;
            SRC_BYP:  fire = enable && byp_valid;
            SRC_CNT:  fire = enable;
            default:  fire = 1'b0;
        endcase
    end

    // R9
    mid_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !first_beat |=> (state_q == $past(state_q)));

endmodule

// File: rtl/cnt_stream_src.sv
module cnt_stream_src
    import css_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SAMPLE_W    = 16,
    parameter int FRAME_LEN   = 512,
    parameter int FRAME_IDX_W = 16,
    localparam int DATA_W     = LANES * 2 * SAMPLE_W,
    localparam int BEATS      = FRAME_LEN / LANES,
    localparam int BEAT_W     = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] chan_data,
    input  logic              chan_valid,
    input  logic [DATA_W-1:0] byp_data,
    input  logic              byp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              smp_valid,
    output logic              frame_end
);

    logic [BEAT_W-1:0]      beat;
    logic [FRAME_IDX_W-1:0] frame;
    logic                   first_beat;
    logic                   last_beat;
    logic                   fire;
    src_e                   src;
    logic [DATA_W-1:0]      cnt_word;
    logic [DATA_W-1:0]      next_word;

    css_src_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode_sel   (mode_sel),
        .first_beat (first_beat),
        .chan_valid (chan_valid),
        .byp_valid  (byp_valid),
        .src        (src),
        .fire       (fire)
    );

    css_frame_track #(
        .BEATS       (BEATS),
        .FRAME_IDX_W (FRAME_IDX_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (fire),
        .beat       (beat),
        .frame      (frame),
        .first_beat (first_beat),
        .last_beat  (last_beat)
    );

    css_pattern_gen #(
        .LANES       (LANES),
        .SAMPLE_W    (SAMPLE_W),
        .FRAME_IDX_W (FRAME_IDX_W),
        .BEAT_W      (BEAT_W)
    ) u_pat (
        .beat  (beat),
        .frame (frame),
        .word  (cnt_word)
    );

    always_comb begin
        unique case (src)
            SRC_CHAN: next_word = chan_data;
            SRC_BYP:  next_word = byp_data;
            SRC_CNT:  next_word = cnt_word;
            default:  next_word = cnt_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_data  <= '0;
            smp_valid <= 1'b0;
            frame_end <= 1'b0;
        end else if (fire) begin
            smp_data  <= next_word;
            smp_valid <= 1'b1;
            frame_end <= last_beat;
        end else begin
            smp_valid <= 1'b0;
            frame_end <= 1'b0;
        end
    end

    // R6
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !smp_valid);

    // R5
    end_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> smp_valid);

endmodule

// File: tb/cnt_stream_src_bench.sv
module cnt_stream_src_bench;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic         enable;
    logic [1:0]   mode_sel;
    logic [127:0] chan_data, byp_data;
    logic         chan_valid, byp_valid;
    logic [127:0] smp_data;
    logic         smp_valid, frame_end;

    logic [127:0] w_data;
    logic         w_valid, w_end;

    cnt_stream_src u_cnt_stream_src (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
        .chan_data(chan_data), .chan_valid(chan_valid),
        .byp_data(byp_data), .byp_valid(byp_valid),
        .smp_data(smp_data), .smp_valid(smp_valid), .frame_end(frame_end)
    );

    cnt_stream_src #(.FRAME_IDX_W(3)) u_cnt_stream_src_wrap (
        .clk(clk), .rst_n(rst_n), .enable(1'b1), .mode_sel(2'b10),
        .chan_data('0), .chan_valid(1'b0),
        .byp_data('0), .byp_valid(1'b0),
        .smp_data(w_data), .smp_valid(w_valid), .frame_end(w_end)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [129:0] exp_q[$];
    string        tag_q[$];

    int         m_beat  = 0;
    int         m_frame = 0;
    logic [1:0] m_mode  = 2'd2;
    int         seq     = 0;

    function automatic logic [1:0] dec(input logic [1:0] s);
        return (s == 2'd0) ? 2'd0 : (s == 2'd1) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [127:0] cnt_word(input int b, input int f);
        logic [127:0] w;
        for (int k = 0; k < 4; k++) begin
            w[32*k +: 16]      = 16'(b*4 + k);
            w[32*k + 16 +: 16] = 16'(f);
        end
        return w;
    endfunction

    task automatic step(input logic en, input logic [1:0] ms,
                        input logic cv, input logic bv, input string tag);
        logic [1:0]   eff;
        logic         srcv;
        logic [127:0] d;
        logic         lst;
        @(negedge clk);
        seq++;
        enable     = en;
        mode_sel   = ms;
        chan_valid = cv;
        byp_valid  = bv;
        chan_data  = {4{32'hC0000000 | 32'(seq)}};
        byp_data   = {4{32'hB0000000 ^ 32'(seq * 7)}};
        eff    = (m_beat == 0) ? dec(ms) : m_mode;
        m_mode = eff;
        srcv   = (eff == 2'd2) ? 1'b1 : (eff == 2'd0) ? cv : bv;
        if (en && srcv) begin
            d   = (eff == 2'd2) ? cnt_word(m_beat, m_frame) :
                  (eff == 2'd0) ? chan_data : byp_data;
            lst = (m_beat == 127);
            exp_q.push_back({1'b1, lst, d});
            m_beat = (m_beat + 1) % 128;
            if (lst) m_frame++;
        end else begin
            exp_q.push_back({2'b00, 128'd0});
        end
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    initial begin
        logic [129:0] it;
        string        tg;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                total++;
                if (smp_valid !== it[129] ||
                    (it[129] && (frame_end !== it[128] || smp_data !== it[127:0]))) begin
                    bad++;
                    $display("FAIL %s: got v=%0b e=%0b d=%h, expected v=%0b e=%0b d=%h",
                             tg, smp_valid, frame_end, smp_data, it[129], it[128], it[127:0]);
                end
            end
        end
    end

    // R7: frame index wrap on the 3-bit instance
    initial begin
        int wf;
        wf = 0;
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && w_valid && w_end && wf < 10) begin
                total++;
                if (w_data[16 +: 16] !== 16'(wf % 8) || w_data[96 +: 16] !== 16'd511) begin
                    bad++;
                    $display("FAIL R7: got imag=%0d real3=%0d, expected imag=%0d real3=511",
                             w_data[16 +: 16], w_data[96 +: 16], wf % 8);
                end
                wf++;
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; mode_sel = 2'd2;
        chan_data = '0; byp_data = '0; chan_valid = 1'b0; byp_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        total++;
        if (smp_valid !== 1'b0 || frame_end !== 1'b0 || smp_data !== '0) begin
            bad++;
            $display("FAIL R1: got v=%0b e=%0b d=%h, expected 0 0 0", smp_valid, frame_end, smp_data);
        end
        rst_n = 1'b1;
        // R1 R2 R3 R4 R5: two full counter frames
        for (int i = 0; i < 256; i++) step(1'b1, 2'd2, 1'b0, 1'b0, "R1 R2 R3 R4 R5");
        // R6: enable gaps
        for (int i = 0; i < 200; i++) step((i % 3) != 0, 2'd2, 1'b0, 1'b0, "R6");
        // R9: request channelizer mid-frame
        for (int i = 0; i < 300; i++) step(1'b1, 2'd0, 1'b1, 1'b0, "R9");
        // R8: channelizer with valid gaps, then bypass
        for (int i = 0; i < 128; i++) step(1'b1, 2'd0, (i % 2) == 0, 1'b0, "R8");
        for (int i = 0; i < 400; i++) step(1'b1, 2'd1, 1'b1, (i % 4) != 3, "R8");
        // R8 R10: counter via code 11 after passthrough frames
        for (int i = 0; i < 300; i++) step(1'b1, 2'd3, 1'b0, 1'b1, "R8 R10");
        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule